// File: doc/BRIEF.md
# Sensor Readout Pixel Region Classifier

This block follows the position of every sample that a full-frame image sensor shifts out and labels each sample with the kind of site it came from. The labels are: virtual dummy shift phase, dummy shift phase, test-monitor pixel, dark dummy pixel, dark reference pixel, active buffer pixel and active image pixel. Three strobes drive it. A valid strobe marks each sample. A line-start pulse opens a new line. A frame-start pulse opens a new frame.

The column and row counters are looked up in two segment tables. The horizontal table has 3448 positions per line and the vertical table has 2574 lines per frame. The two labels are merged into a single registered code. That code comes out one cycle after its sample, together with the row and column it was taken at. Two flags are also given. One marks active image samples. The other marks samples that are a usable dark reference. Only the 39 trailing dark columns and the 12 full dark lines qualify as dark reference, and never any dummy, virtual or dark dummy site. The segment tables, their lengths and the counter widths are parameters.

Top module: `pixelRegionClassifier`

## Requirements
- R1: While reset is low and after it: outValid, regionCode index outputs, activeFlag, darkRefFlag and overflowSticky read 0, except regionCode, which reads 5 (dummy).
- R2: A sample taken together with a line-start or frame-start pulse gets column 0. Each further sample in the same line gets the previous column plus one. A line-start pulse with no sample still clears the column.
- R3: A frame-start pulse sets the row to 0. Each line-start pulse without frame-start adds one to the row.
- R4: The column label follows this order. Columns 0-3 are virtual (6), 4-11 dummy (5), 12 monitor (4), 13-17 dummy, 18-22 dark dummy (3), 23-42 buffer (1), 43-3368 active (0), 3369-3388 buffer, 3389-3396 dark dummy, 3397-3435 dark (2), 3436-3441 dark dummy, 3442-3444 dummy, 3445 monitor and 3446-3447 dummy.
- R5: The row label follows this order. Rows 0-7 are dark dummy, 8-19 dark, 20-25 dark dummy, 26-45 buffer, 46-2549 active, 2550-2569 buffer, 2570-2572 dark dummy and 2573 monitor.
- R6: The 3-bit code is active=0, buffer=1, dark=2, dark dummy=3, monitor=4, dummy=5, virtual=6. The output code is the larger of the row code and the column code.
- R7: activeFlag is 1 exactly when the sample's code is 0. darkRefFlag is 1 exactly when the code is 2.
- R8: A sample at column 3448 or above, or at row 2574 or above, is labelled dummy (5). It also sets overflowSticky, which stays 1 until reset.
- R9: outValid is 1 in the cycle after a sample and 0 otherwise. With no sample, regionCode, rowIdx, colIdx and the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | A sample is present this cycle |
| lineStart | input | 1 | New line begins this cycle |
| frameStart | input | 1 | New frame begins this cycle (also starts a line) |
| outValid | output | 1 | Registered outputs describe a new sample |
| regionCode | output | 3 | Region label of the sample |
| rowIdx | output | 12 | Row the sample was taken at |
| colIdx | output | 12 | Column the sample was taken at |
| activeFlag | output | 1 | Sample is active image |
| darkRefFlag | output | 1 | Sample is a usable dark reference |
| overflowSticky | output | 1 | A sample fell outside the defined frame |

## Verification
The frame is swept with a short line on every row, covering columns 0-44. That crosses every horizontal boundary up to the first active column against every row type, so row-code wins are told apart from column-code wins. Full 3448-sample lines on a dark row, an active row, a trailing dark dummy row and the monitor row reach the trailing dark, dark dummy and monitor columns. These lines separate the usable dark columns from their dark dummy neighbours. Lines past the last row, a line running beyond the last column, idle gaps, a frame start with no sample and a line start with no sample separate the overflow, hold and counter-clear behaviour. Each cycle is compared against a behavioural model of the counters.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

  typedef enum logic [2:0] {
    RC_ACTIVE     = 3'd0,
    RC_BUFFER     = 3'd1,
    RC_DARK       = 3'd2,
    RC_DARK_DUMMY = 3'd3,
    RC_MONITOR    = 3'd4,
    RC_DUMMY      = 3'd5,
    RC_VIRTUAL    = 3'd6
  } regionE;

  localparam int COL_SEGS = 14;
  localparam int ROW_SEGS = 8;

  typedef int unsigned colLenA  [COL_SEGS];
  typedef logic [2:0]  colCodeA [COL_SEGS];
  typedef int unsigned rowLenA  [ROW_SEGS];
  typedef logic [2:0]  rowCodeA [ROW_SEGS];

  // Horizontal readout order within one line
  localparam colLenA DEF_COL_LEN = '{4, 8, 1, 5, 5, 20, 3326, 20, 8, 39, 6, 3, 1, 2};
  localparam colCodeA DEF_COL_CODE = '{
    RC_VIRTUAL, RC_DUMMY, RC_MONITOR, RC_DUMMY, RC_DARK_DUMMY, RC_BUFFER, RC_ACTIVE,
    RC_BUFFER, RC_DARK_DUMMY, RC_DARK, RC_DARK_DUMMY, RC_DUMMY, RC_MONITOR, RC_DUMMY};

  // Vertical readout order within one frame
  localparam rowLenA DEF_ROW_LEN = '{8, 12, 6, 20, 2504, 20, 3, 1};
  localparam rowCodeA DEF_ROW_CODE = '{
    RC_DARK_DUMMY, RC_DARK, RC_DARK_DUMMY, RC_BUFFER, RC_ACTIVE, RC_BUFFER,
    RC_DARK_DUMMY, RC_MONITOR};

  // Strobes from control to datapath
  typedef struct packed {
    logic take;      // a sample is present
    logic newLine;   // column restarts
    logic newFrame;  // row restarts
  } ctrlS;

  function automatic int unsigned colTotal(colLenA a);
    int unsigned s = 0;
    for (int i = 0; i < COL_SEGS; i++) s += a[i];
    return s;
  endfunction

  function automatic int unsigned rowTotal(rowLenA a);
    int unsigned s = 0;
    for (int i = 0; i < ROW_SEGS; i++) s += a[i];
    return s;
  endfunction

endpackage

// File: rtl/pxrSegLookup.sv
module pxrSegLookup #(
  parameter int          N     = 1,
  parameter int unsigned LEN  [N] = '{default: 1},
  parameter logic [2:0]  CODE [N] = '{default: 3'd5},
  parameter int          IDX_W = 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [2:0]       code,
  output logic             outOfRange
);

  function automatic int unsigned startOf(int k);
    int unsigned s = 0;
    for (int i = 0; i < k; i++) s += LEN[i];
    return s;
  endfunction

  localparam int unsigned TOTAL = startOf(N);

  logic [N-1:0] hit;
  logic [31:0]  idxWide;

  assign idxWide = 32'(idx);

  for (genvar g = 0; g < N; g++) begin : g_seg
    localparam int unsigned SEG_START = startOf(g);
    localparam int unsigned SEG_END   = SEG_START + LEN[g];
    assign hit[g] = (idxWide >= SEG_START) && (idxWide < SEG_END);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) code = code | CODE[i];
    end
  end

  assign outOfRange = idxWide >= TOTAL;

endmodule

// File: rtl/pxrCtrl.sv
module pxrCtrl
  import pxr_pkg::*;
(
  input  logic pixValid,
  input  logic lineStart,
  input  logic frameStart,
  output ctrlS strobe
);

  // A frame start always opens a line as well
  always_comb begin
    strobe.take     = pixValid;
    strobe.newLine  = lineStart | frameStart;
    strobe.newFrame = frameStart;
  end

endmodule

// File: rtl/pxrDatapath.sv
module pxrDatapath
  import pxr_pkg::*;
#(
  parameter colLenA  COL_LEN  = DEF_COL_LEN,
  parameter colCodeA COL_CODE = DEF_COL_CODE,
  parameter rowLenA  ROW_LEN  = DEF_ROW_LEN,
  parameter rowCodeA ROW_CODE = DEF_ROW_CODE,
  parameter int      COL_W    = 12,
  parameter int      ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlS             strobe,
  output logic             outValid,
  output logic [2:0]       regionCode,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx,
  output logic             activeFlag,
  output logic             darkRefFlag,
  output logic             overflowSticky
);

  localparam logic [COL_W-1:0] COL_SAT = '1;
  localparam logic [ROW_W-1:0] ROW_SAT = '1;

  logic [COL_W-1:0] colCnt, curCol;
  logic [ROW_W-1:0] rowCnt, curRow;
  logic [2:0]       colCode, rowCode, merged;
  logic             colOor, rowOor, anyOor;

  // Position of the sample in this cycle
  always_comb begin
    curCol = strobe.newLine ? '0 : colCnt;
    if (strobe.newFrame)                         curRow = '0;
    else if (strobe.newLine && rowCnt != ROW_SAT) curRow = rowCnt + 1'b1;
    else                                         curRow = rowCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else begin
      if (strobe.newLine) rowCnt <= curRow;
      if (strobe.take)         colCnt <= (curCol == COL_SAT) ? curCol : curCol + 1'b1;
      else if (strobe.newLine) colCnt <= '0;
    end
  end

  pxrSegLookup #(
    .N(COL_SEGS), .LEN(COL_LEN), .CODE(COL_CODE), .IDX_W(COL_W)
  ) u_colLookup (
    .idx(curCol), .code(colCode), .outOfRange(colOor)
  );

  pxrSegLookup #(
    .N(ROW_SEGS), .LEN(ROW_LEN), .CODE(ROW_CODE), .IDX_W(ROW_W)
  ) u_rowLookup (
    .idx(curRow), .code(rowCode), .outOfRange(rowOor)
  );

  // Higher code is the less image-like label and wins
  always_comb begin
    anyOor = colOor | rowOor;
    if (anyOor)                 merged = RC_DUMMY;
    else if (colCode > rowCode) merged = colCode;
    else                        merged = rowCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      regionCode     <= RC_DUMMY;
      rowIdx         <= '0;
      colIdx         <= '0;
      activeFlag     <= 1'b0;
      darkRefFlag    <= 1'b0;
      overflowSticky <= 1'b0;
    end else begin
      outValid <= strobe.take;
      if (strobe.take) begin
        regionCode     <= merged;
        rowIdx         <= curRow;
        colIdx         <= curCol;
        activeFlag     <= (merged == RC_ACTIVE);
        darkRefFlag    <= (merged == RC_DARK);
        overflowSticky <= overflowSticky | anyOor;
      end
    end
  end

  // R9: output strobe follows the sample by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> outValid);
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !outValid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> ($stable(regionCode) && $stable(rowIdx) && $stable(colIdx)));

  // R2: back-to-back samples in one line step the column by one
  a_r2_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && strobe.take && !strobe.newLine && colIdx < COL_SAT - 1'b1)
      |=> colIdx == $past(colIdx) + 1'b1);

  // R3: a frame start puts the sample on row zero
  a_r3_frame_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.newFrame) |=> rowIdx == '0);

  // R8: out-of-frame samples are dummy and the flag never drops
  a_r8_oor_dummy: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && (colOor || rowOor)) |=> (regionCode == RC_DUMMY && overflowSticky));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowSticky |=> overflowSticky);

  // R7: the two flags are exclusive and tied to their codes
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(activeFlag && darkRefFlag));
  a_r7_dark_code: assert property (@(posedge clk) disable iff (!rstN)
    darkRefFlag |-> regionCode == RC_DARK);

endmodule

// File: rtl/pixelRegionClassifier.sv
module pixelRegionClassifier
  import pxr_pkg::*;
#(
  parameter colLenA  COL_LEN  = DEF_COL_LEN,
  parameter colCodeA COL_CODE = DEF_COL_CODE,
  parameter rowLenA  ROW_LEN  = DEF_ROW_LEN,
  parameter rowCodeA ROW_CODE = DEF_ROW_CODE,
  localparam int     COL_W    = $clog2(colTotal(COL_LEN) + 2),
  localparam int     ROW_W    = $clog2(rowTotal(ROW_LEN) + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             lineStart,
  input  logic             frameStart,
  output logic             outValid,
  output logic [2:0]       regionCode,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx,
  output logic             activeFlag,
  output logic             darkRefFlag,
  output logic             overflowSticky
);

  ctrlS strobe;

  pxrCtrl u_ctrl (
    .pixValid(pixValid), .lineStart(lineStart), .frameStart(frameStart),
    .strobe(strobe)
  );

  pxrDatapath #(
    .COL_LEN(COL_LEN), .COL_CODE(COL_CODE), .ROW_LEN(ROW_LEN), .ROW_CODE(ROW_CODE),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .outValid(outValid), .regionCode(regionCode), .rowIdx(rowIdx), .colIdx(colIdx),
    .activeFlag(activeFlag), .darkRefFlag(darkRefFlag), .overflowSticky(overflowSticky)
  );

endmodule

// File: tb/test_pixelRegionClassifier.sv
module test_pixelRegionClassifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0, lineStart = 1'b0, frameStart = 1'b0;
  logic        outValid, activeFlag, darkRefFlag, overflowSticky;
  logic [2:0]  regionCode;
  logic [11:0] rowIdx, colIdx;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  // Model state and expected outputs
  int colM = 0, rowM = 0;
  bit stickyM = 1'b0;
  bit expValid = 1'b0, expActive = 1'b0, expDark = 1'b0;
  int expCode = 5, expRow = 0, expCol = 0;

  pixelRegionClassifier i_pixelRegionClassifier (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .outValid(outValid), .regionCode(regionCode),
    .rowIdx(rowIdx), .colIdx(colIdx), .activeFlag(activeFlag),
    .darkRefFlag(darkRefFlag), .overflowSticky(overflowSticky)
  );

  always #5 clk = ~clk;

  // R4 column map, -1 beyond the line
  function automatic int colClass(int c);
    if (c < 4)    return 6;
    if (c < 12)   return 5;
    if (c == 12)  return 4;
    if (c < 18)   return 5;
    if (c < 23)   return 3;
    if (c < 43)   return 1;
    if (c < 3369) return 0;
    if (c < 3389) return 1;
    if (c < 3397) return 3;
    if (c < 3436) return 2;
    if (c < 3442) return 3;
    if (c < 3445) return 5;
    if (c == 3445) return 4;
    if (c < 3448) return 5;
    return -1;
  endfunction

  // R5 row map, -1 beyond the frame
  function automatic int rowClass(int r);
    if (r < 8)     return 3;
    if (r < 20)    return 2;
    if (r < 26)    return 3;
    if (r < 46)    return 1;
    if (r < 2550)  return 0;
    if (r < 2570)  return 1;
    if (r < 2573)  return 3;
    if (r == 2573) return 4;
    return -1;
  endfunction

  task automatic fieldChk(input string tag, input string name, input int act,
                          input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s: %s got %0d expected %0d (row %0d col %0d)",
               tag, name, act, exp, expRow, expCol);
      bad = 1'b1;
    end
  endtask

  task automatic compareAll();
    bit bad = 1'b0;
    compared++;
    fieldChk("R9", "outValid", int'(outValid), int'(expValid), bad);
    fieldChk("R4 R5 R6", "regionCode", int'(regionCode), expCode, bad);
    fieldChk("R3", "rowIdx", int'(rowIdx), expRow, bad);
    fieldChk("R2", "colIdx", int'(colIdx), expCol, bad);
    fieldChk("R7", "activeFlag", int'(activeFlag), int'(expActive), bad);
    fieldChk("R7", "darkRefFlag", int'(darkRefFlag), int'(expDark), bad);
    fieldChk("R8", "overflowSticky", int'(overflowSticky), int'(stickyM), bad);
    if (bad) mismatched++;
  endtask

  task automatic model(input bit v, input bit ls, input bit fs);
    bit nl = ls | fs;
    int cr = fs ? 0 : (ls ? rowM + 1 : rowM);
    int cc = nl ? 0 : colM;
    if (nl) rowM = cr;
    if (v) colM = cc + 1;
    else if (nl) colM = 0;
    expValid = v;
    if (v) begin
      int ck = colClass(cc);
      int rk = rowClass(cr);
      expRow = cr;
      expCol = cc;
      if (ck < 0 || rk < 0) begin
        expCode = 5;   // R8
        stickyM = 1'b1;
      end else begin
        expCode = (ck > rk) ? ck : rk;  // R6
      end
      expActive = (expCode == 0);
      expDark   = (expCode == 2);
    end
  endtask

  // Compare the previous cycle's result, then drive the next inputs
  task automatic step(input bit v, input bit ls, input bit fs);
    @(negedge clk);
    compareAll();
    pixValid = v; lineStart = ls; frameStart = fs;
    model(v, ls, fs);
  endtask

  task automatic runLine(input int n, input bit fs);
    step(1'b1, 1'b1, fs);
    for (int k = 1; k < n; k++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll();
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0);

    // R2 R3 R4 R5 R6 R7: sweep every row, full lines on selected rows
    for (int r = 0; r < 2574; r++) begin
      bit full = (r == 8) || (r == 46) || (r == 2571) || (r == 2573);
      runLine(full ? 3448 : 45, r == 0);
    end
    // R8: rows past the frame
    runLine(3, 1'b0);
    runLine(3, 1'b0);

    // R3: frame start alone, then samples at row 0
    step(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    // R8: line running past the last column
    runLine(3450, 1'b0);
    // R2: line start with no sample, then samples from column 0
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0);
    // R9: idle cycles hold values
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    finishRun();
  end

endmodule